// File: doc/BRIEF.md
# Round-Pipelined AES-128 Encryption Core

This block encrypts 128-bit blocks under AES-128 at a rate of one block per clock. The ten cipher rounds are unrolled into separate hardware stages, with one register after each. An initial key-addition stage comes before them. A block presented with `in_valid` high leaves the core eleven clock edges later as ciphertext, with `out_valid` high. Blocks may be presented back to back or with gaps. Any pattern of idle cycles on the input shows up unchanged on the output.

The core holds no key schedule. A key expander outside the core, which several such cores can share, drives all eleven round keys on one wide bus. Each stage takes its key from that bus in the cycle the block passes through that stage. The keys must therefore stay stable while any block of that key is still in flight.

Top module: `aes128_round_pipe`

## Requirements
- R1: A synchronous active-high `rst` sampled at a rising edge makes `out_valid` low after that edge.
- R2: A block sampled with `in_valid` high at clock edge k appears on `out_block` with `out_valid` high right after edge k+10, which is the eleventh register edge counting edge k.
- R3: `out_valid` reproduces the sequence of `in_valid`, delayed by the same eleven edges, including every idle gap.
- R4: For key 000102030405060708090a0b0c0d0e0f and plaintext 00112233445566778899aabbccddeeff, the output is 69c4e0d86a7b0430d8cdb78070b4c55a.
- R5: Block byte n (n = 0..15) is bits [127-8n -: 8], with bytes filling the state column by column. Round key i (i = 0..10) sits on `round_keys[128*i +: 128]` with the same byte order. Round 0 is a plain key addition, rounds 1 to 9 are full rounds, and round 10 leaves out column mixing. The output must match AES-128 for arbitrary keys and blocks.
- R6: Blocks presented on consecutive cycles each produce their own ciphertext on consecutive cycles, with no stall and no block lost.
- R7: Blocks in flight when `rst` is asserted never emerge. After reset is released, `out_valid` stays low until eleven edges after the first new valid input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A plaintext block is present this cycle |
| in_block | input | 128 | Plaintext block, byte 0 in the top bits |
| round_keys | input | 1408 | Eleven round keys; key i on bits [128*i +: 128] |
| out_valid | output | 1 | Ciphertext on `out_block` is valid |
| out_block | output | 128 | Ciphertext block |

## Verification
On every cycle, the assertions check the valid timing: reset clearing, the exact eleven-edge delay of the valid pattern, silence after reset, and a fully known block whenever `out_valid` is high. Whether the ciphertext is correct can only be shown by the bench's scenarios. These compare every output block against a separate AES-128 reference model. The scenarios cover the standard test vector, random keys with random and back-to-back blocks, sparse valid patterns and a reset in mid-stream.

// File: rtl/aes_enc_pkg.sv
package aes_enc_pkg;

    localparam int BLK_W   = 128;
    localparam int BYTE_W  = 8;
    localparam int NBYTES  = BLK_W / BYTE_W;
    localparam int NROWS   = 4;
    localparam int NCOLS   = NBYTES / NROWS;
    localparam int COL_W   = NROWS * BYTE_W;
    localparam int NROUNDS = 10;
    localparam int NKEYS   = NROUNDS + 1;
    localparam int RK_W    = NKEYS * BLK_W;

    typedef logic [BLK_W-1:0]  block_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic   vld;
        block_t blk;
    } stage_t;

    // Multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
    function automatic byte_t gf_dbl(input byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc;
        byte_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_dbl(sh);
        end
        return acc;
    endfunction

    // a^254 is the multiplicative inverse; zero maps to zero
    function automatic byte_t gf_inv(input byte_t a);
        byte_t pw;
        byte_t res;
        pw  = a;
        res = 8'h01;
        for (int i = 1; i < BYTE_W; i++) begin
            pw  = gf_mul(pw, pw);
            res = gf_mul(res, pw);
        end
        return res;
    endfunction

    function automatic byte_t rotl8(input byte_t a, input int n);
        return byte_t'((a << n) | (a >> (BYTE_W - n)));
    endfunction

    // Forward substitution: inversion then affine map
    function automatic byte_t sub_byte(input byte_t a);
        byte_t b;
        b = gf_inv(a);
        return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
    endfunction

    // Row r of column c lives in byte r + NROWS*c, byte 0 at the top
    function automatic block_t shift_rows(input block_t s);
        block_t o;
        o = '0;
        for (int c = 0; c < NCOLS; c++) begin
            for (int r = 0; r < NROWS; r++) begin
                o[BLK_W-1-BYTE_W*(r+NROWS*c) -: BYTE_W] =
                    s[BLK_W-1-BYTE_W*(r+NROWS*((c+r)%NCOLS)) -: BYTE_W];
            end
        end
        return o;
    endfunction

    function automatic logic [COL_W-1:0] mix_one(input logic [COL_W-1:0] col);
        byte_t a0, a1, a2, a3;
        a0 = col[31:24];
        a1 = col[23:16];
        a2 = col[15:8];
        a3 = col[7:0];
        return { gf_dbl(a0) ^ gf_dbl(a1) ^ a1 ^ a2 ^ a3,
                 a0 ^ gf_dbl(a1) ^ gf_dbl(a2) ^ a2 ^ a3,
                 a0 ^ a1 ^ gf_dbl(a2) ^ gf_dbl(a3) ^ a3,
                 gf_dbl(a0) ^ a0 ^ a1 ^ a2 ^ gf_dbl(a3) };
    endfunction

    function automatic block_t mix_columns(input block_t s);
        block_t o;
        for (int c = 0; c < NCOLS; c++) begin
            o[BLK_W-1-COL_W*c -: COL_W] = mix_one(s[BLK_W-1-COL_W*c -: COL_W]);
        end
        return o;
    endfunction

endpackage

// File: rtl/aes_sbox_bank.sv
module aes_sbox_bank
    import aes_enc_pkg::*;
#(
    parameter int LANES = NBYTES
) (
    input  logic [LANES*BYTE_W-1:0] din,
    output logic [LANES*BYTE_W-1:0] dout
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dout[BYTE_W*g +: BYTE_W] = sub_byte(din[BYTE_W*g +: BYTE_W]);
    end

endmodule

// File: rtl/aes_round_stage.sv
module aes_round_stage
    import aes_enc_pkg::*;
#(
    parameter bit FINAL = 1'b0
) (
    input  logic   clk,
    input  logic   rst,
    input  stage_t d,
    input  block_t rkey,
    output stage_t q
);

    block_t subbed;
    block_t shifted;
    block_t mixed;

    aes_sbox_bank #(.LANES(NBYTES)) u_sbox (
        .din  (d.blk),
        .dout (subbed)
    );

    assign shifted = shift_rows(subbed);

    if (FINAL) begin : g_last
        assign mixed = shifted;
    end else begin : g_full
        assign mixed = mix_columns(shifted);
    end

    always_ff @(posedge clk) begin
        if (rst) q.vld <= 1'b0;
        else     q.vld <= d.vld;
    end

    always_ff @(posedge clk) begin
        q.blk <= mixed ^ rkey;
    end

endmodule

// File: rtl/aes128_round_pipe.sv
module aes128_round_pipe
    import aes_enc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BLK_W-1:0]  in_block,
    input  logic [RK_W-1:0]   round_keys,
    output logic              out_valid,
    output logic [BLK_W-1:0]  out_block
);

    stage_t pipe [NKEYS];

    // Stage 0: whitening with round key 0
    always_ff @(posedge clk) begin
        if (rst) pipe[0].vld <= 1'b0;
        else     pipe[0].vld <= in_valid;
    end

    always_ff @(posedge clk) begin
        pipe[0].blk <= in_block ^ round_keys[0 +: BLK_W];
    end

    for (genvar r = 1; r <= NROUNDS; r++) begin : g_round
        aes_round_stage #(.FINAL(r == NROUNDS)) u_round (
            .clk  (clk),
            .rst  (rst),
            .d    (pipe[r-1]),
            .rkey (round_keys[r*BLK_W +: BLK_W]),
            .q    (pipe[r])
        );
    end

    assign out_valid = pipe[NROUNDS].vld;
    assign out_block = pipe[NROUNDS].blk;

endmodule

// File: rtl/aes128_round_pipe_chk.sv
module aes128_round_pipe_chk
    import aes_enc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             out_valid,
    input logic [BLK_W-1:0] out_block
);

    localparam int LAT = NKEYS;
    localparam int CW  = $clog2(LAT + 1);

    logic [LAT-1:0] hist;
    logic [CW-1:0]  since;
    logic           rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            hist  <= '0;
            since <= '0;
        end else begin
            hist <= {hist[LAT-2:0], in_valid};
            if (since != CW'(LAT)) since <= since + 1'b1;
        end
    end

    // R1: the edge after reset leaves the output idle
    p_reset_clears_r1: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> !out_valid);

    // R2 and R3: output valid is the input valid pattern eleven edges late
    p_valid_delay_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid == hist[LAT-1]);

    // R7: nothing emerges before a post-reset input could have crossed the pipe
    p_quiet_after_reset_r7: assert property (@(posedge clk) disable iff (rst)
        (since < CW'(LAT)) |-> !out_valid);

    // R4: a valid ciphertext is fully defined
    p_known_block_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !$isunknown(out_block));

endmodule

bind aes128_round_pipe aes128_round_pipe_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_block (out_block)
);

// File: tb/aes128_round_pipe_bench.sv
module aes128_round_pipe_bench;

    localparam int DEPTH = 4096;
    localparam int LAT   = 11;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [127:0]  in_block = '0;
    logic [1407:0] round_keys = '0;
    logic          out_valid;
    logic [127:0]  out_block;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit armed  = 1'b0;
    bit done   = 1'b0;

    bit           exp_v [DEPTH];
    logic [127:0] exp_b [DEPTH];
    string        exp_t [DEPTH];
    logic [7:0]   sb [256];
    logic [127:0] rk [11];

    aes128_round_pipe u_aes128_round_pipe (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_block   (in_block),
        .round_keys (round_keys),
        .out_valid  (out_valid),
        .out_block  (out_block)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- reference model ----------------
    function automatic logic [7:0] xt(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] rl(input logic [7:0] a, input int n);
        return (a << n) | (a >> (8 - n));
    endfunction

    task automatic build_sbox();
        logic [7:0] p = 8'h01;
        logic [7:0] q = 8'h01;
        do begin
            p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
            q = q ^ {q[6:0], 1'b0};
            q = q ^ {q[5:0], 2'b0};
            q = q ^ {q[3:0], 4'b0};
            if (q[7]) q = q ^ 8'h09;
            sb[p] = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4) ^ 8'h63;
        end while (p != 8'h01);
        sb[0] = 8'h63;
    endtask

    task automatic load_key(input logic [127:0] key);
        logic [31:0] w [44];
        logic [7:0]  rc = 8'h01;
        for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            logic [31:0] t = w[i-1];
            if (i % 4 == 0) begin
                t = {t[23:0], t[31:24]};
                t = {sb[t[31:24]] ^ rc, sb[t[23:16]], sb[t[15:8]], sb[t[7:0]]};
                rc = xt(rc);
            end
            w[i] = w[i-4] ^ t;
        end
        for (int k = 0; k < 11; k++) begin
            rk[k] = {w[4*k], w[4*k+1], w[4*k+2], w[4*k+3]};
            round_keys[128*k +: 128] = rk[k];
        end
    endtask

    function automatic logic [127:0] ref_enc(input logic [127:0] pt);
        logic [7:0] s [16];
        logic [7:0] t [16];
        for (int n = 0; n < 16; n++) s[n] = pt[127-8*n -: 8] ^ rk[0][127-8*n -: 8];
        for (int r = 1; r <= 10; r++) begin
            for (int n = 0; n < 16; n++) t[n] = sb[s[n]];
            for (int n = 0; n < 16; n++) s[n] = t[(n % 4) + 4 * (((n / 4) + (n % 4)) % 4)];
            if (r != 10) begin
                for (int c = 0; c < 4; c++) begin
                    logic [7:0] a0 = s[4*c], a1 = s[4*c+1], a2 = s[4*c+2], a3 = s[4*c+3];
                    logic [7:0] x  = a0 ^ a1 ^ a2 ^ a3;
                    s[4*c]   = a0 ^ x ^ xt(a0 ^ a1);
                    s[4*c+1] = a1 ^ x ^ xt(a1 ^ a2);
                    s[4*c+2] = a2 ^ x ^ xt(a2 ^ a3);
                    s[4*c+3] = a3 ^ x ^ xt(a3 ^ a0);
                end
            end
            for (int n = 0; n < 16; n++) s[n] = s[n] ^ rk[r][127-8*n -: 8];
        end
        ref_enc = '0;
        for (int n = 0; n < 16; n++) ref_enc[127-8*n -: 8] = s[n];
    endfunction

    // ---------------- checking ----------------
    task automatic check_out();
        int idx = cyc % DEPTH;
        if (!armed) return;
        checks++;
        if (out_valid !== exp_v[idx]) begin
            fails++;
            $display("FAIL R3/R2 cycle %0d out_valid=%0b expected %0b", cyc, out_valid, exp_v[idx]);
        end else if (exp_v[idx]) begin
            checks++;
            if (out_block !== exp_b[idx]) begin
                fails++;
                $display("FAIL %s cycle %0d out_block=%h expected %h", exp_t[idx], cyc, out_block, exp_b[idx]);
            end
        end
        exp_v[idx] = 1'b0;
    endtask

    // Check this cycle's outputs, then drive the next input
    task automatic step(input bit v, input logic [127:0] blk, input string tag,
                        input bit r = 1'b0, input bit use_lit = 1'b0,
                        input logic [127:0] lit = '0);
        @(negedge clk);
        check_out();
        rst      = r;
        in_valid = v;
        in_block = blk;
        if (r) begin
            for (int i = 0; i < DEPTH; i++) exp_v[i] = 1'b0;
        end else if (v) begin
            int idx = (cyc + LAT) % DEPTH;
            exp_v[idx] = 1'b1;
            exp_b[idx] = use_lit ? lit : ref_enc(blk);
            exp_t[idx] = tag;
        end
    endtask

    task automatic drain();
        for (int i = 0; i < LAT + 2; i++) step(1'b0, '0, "R3");
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) exp_v[i] = 1'b0;
        build_sbox();
        void'($urandom(32'd20211));
        load_key(128'h000102030405060708090a0b0c0d0e0f);

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 out_valid=%0b expected 0 under reset", out_valid);
        end
        armed = 1'b1;
        step(1'b0, '0, "R1");

        // R4: standard vector, model self-check and hard-coded ciphertext
        checks++;
        if (ref_enc(128'h00112233445566778899aabbccddeeff) !== 128'h69c4e0d86a7b0430d8cdb78070b4c55a) begin
            fails++;
            $display("FAIL R4 reference model=%h expected %h",
                     ref_enc(128'h00112233445566778899aabbccddeeff), 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
        end
        // R2: single isolated block, checked at exactly the eleventh edge
        step(1'b1, 128'h00112233445566778899aabbccddeeff, "R4", 1'b0, 1'b1,
             128'h69c4e0d86a7b0430d8cdb78070b4c55a);
        drain();

        // R6: back-to-back burst, same key
        for (int i = 0; i < 24; i++) step(1'b1, rnd128(), "R6");
        // R3: sparse and alternating valid patterns
        for (int i = 0; i < 20; i++) step(i[0], rnd128(), "R3");
        for (int i = 0; i < 30; i++) step(($urandom() % 4) == 0, rnd128(), "R3");
        drain();

        // R5: random keys, mixed traffic including corner blocks
        for (int k = 0; k < 8; k++) begin
            load_key(k == 0 ? '0 : (k == 1 ? '1 : rnd128()));
            step(1'b1, '0, "R5");
            step(1'b1, '1, "R5");
            for (int i = 0; i < 40; i++) step(($urandom() % 10) < 7, rnd128(), "R5");
            drain();
        end

        // R7: reset in mid-stream drops in-flight blocks
        for (int i = 0; i < 6; i++) step(1'b1, rnd128(), "R7");
        step(1'b1, rnd128(), "R7", 1'b1);
        step(1'b1, rnd128(), "R7", 1'b1);
        drain();
        drain();
        // and the pipe works again afterwards
        for (int i = 0; i < 10; i++) step(1'b1, rnd128(), "R7");
        drain();

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            summary();
            $finish;
        end
    end

endmodule